// File: doc/BRIEF.md
# Asynchronous SRAM Test Sequencer

This block is a synchronous controller that tests an external asynchronous static RAM with 12 address lines and 4 data lines. It drives the address, an active-low chip select, an active-low write strobe and a data bus that it can release. It then runs one fixed program of 45 steps. First comes a walk that writes thermometer-coded addresses with Gray-coded data and reads them all back. Next, an inhibit check proves that a write attempted with the chip deselected leaves the stored word alone. Last, each data line is checked on its own at address 0.

Every step is built from phases: address setup, chip enable, write strobe, write completion, and read. Each phase lasts a number of clocks set by a parameter, with a minimum of one. A start pulse launches the program and done marks its end. The first mismatch sets fail and records the address, the expected bits and the observed bits. The sequencer then stops at once. The RAM itself is outside the block. The bus is split into an output value, an output enable and an input value, so that the surrounding logic can build the pad or a model from them.

Top module: `sram_test_seq`

## Requirements
- R1: A synchronous active-high reset forces idle. In idle, ram_ce_n=1, ram_we_n=1, ram_dq_oe=0, done=0 and fail=0.
- R2: ram_dq_oe may rise only while ram_we_n is low. It stays high only through the write strobe and the completion phase. It is low in the cycle where ram_ce_n falls and in the cycle before it. It is never high while the RAM is being read (ram_ce_n=0 and ram_we_n=1).
- R3: A write step follows a fixed order. First, the address is held with both controls high for SETUP_CYC clocks. Then ram_ce_n is low for ENABLE_CYC clocks. Then ram_we_n is low with the data driven for STROBE_CYC clocks. Finally, ram_ce_n and ram_we_n rise in the same clock while the data stays driven for HOLD_CYC clocks. The address does not change while the write strobe falls.
- R4: The walk makes 13 writes. Write i (i = 0..12) goes to the address whose low i bits are 1 (0x000, 0x001, 0x003 … 0xFFF). Its data is i XOR (i>>1), which gives 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010. All 13 writes finish before the first read. The 13 reads then visit the same addresses in the same order and compare all 4 bits.
- R5: The inhibit check writes 1111 to address 0. It then runs a full write step with data 0000 while ram_ce_n is held high. A read of address 0 must then return 1111.
- R6: For each data bit b from 0 to 3 in turn, the block works at address 0. It writes 0000 and reads back, comparing bit b only. It then writes the word with only bit b set (1<<b) and reads back, again comparing bit b only.
- R7: A read step holds the address with both controls high for SETUP_CYC clocks. It then holds ram_ce_n low and ram_we_n high for READ_CYC clocks. ram_dq_in is sampled on the clock edge that ends the last of those clocks.
- R8: The first mismatch sets fail and done. It latches fail_addr as the address, fail_exp as the expected word ANDed with the compare mask, and fail_act as the observed word ANDed with the same mask. The program then stops. These outputs hold until the next accepted start or reset.
- R9: After a start with no mismatch, done rises exactly 23·(SETUP_CYC+ENABLE_CYC+STROBE_CYC+HOLD_CYC) + 22·(SETUP_CYC+READ_CYC) clocks after the start edge. While done is high, both controls are high and the bus is released.
- R10: start is accepted only in idle or once done is high. An accepted start clears fail and restarts from step 0. A start during a run has no effect on the run or on its length.
- R11: A reset in the middle of a run returns the block to idle. It stays idle until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the test program |
| ram_addr | output | 12 | RAM address lines |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 4 | Value driven onto the data bus |
| ram_dq_oe | output | 1 | Data bus drive enable (0 = released) |
| ram_dq_in | input | 4 | Value seen on the data bus |
| done | output | 1 | Program finished or stopped on failure |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | 12 | Address of the first mismatch |
| fail_exp | output | 4 | Expected bits (masked) at the first mismatch |
| fail_act | output | 4 | Observed bits (masked) at the first mismatch |

## Verification
Two events can land on the same edge. The comparison of the very last read, which checks bit 3 of address 0, happens on the same edge on which the program would normally end and raise done. The bench provokes this with a read fault that turns on only for the final read. That fault forces bit 3 to 0. The bench then expects fail together with done after exactly the full program length, with address 0, expected bits 1000 and observed bits 0000. A start pulse sent in the middle of a run is also judged by counting clocks: the run length must equal the unperturbed value.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  localparam int unsigned SEQ_AW  = 12;
  localparam int unsigned SEQ_DW  = 4;
  localparam int unsigned N_WALK  = SEQ_AW + 1;
  localparam int unsigned N_INH   = 3;
  localparam int unsigned N_PIN   = 4 * SEQ_DW;
  localparam int unsigned N_STEPS = 2 * N_WALK + N_INH + N_PIN;
  localparam int unsigned STEP_W  = $clog2(N_STEPS);

  typedef logic [SEQ_AW-1:0] addr_t;
  typedef logic [SEQ_DW-1:0] data_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_t;
  typedef enum logic [2:0] {PH_SETUP, PH_ENABLE, PH_STROBE, PH_HOLD, PH_READ} seq_phase_t;

  typedef struct packed {
    logic  is_read;
    logic  inhibit;
    addr_t addr;
    data_t data;
    data_t mask;
  } seq_op_t;

  // address with the lowest 'ones' bits set
  function automatic addr_t therm_addr(int unsigned ones);
    addr_t a;
    for (int unsigned j = 0; j < SEQ_AW; j++) a[j] = (j < ones);
    return a;
  endfunction

  function automatic data_t gray_code(int unsigned idx);
    int unsigned g;
    g = idx ^ (idx >> 1);
    return data_t'(g);
  endfunction

  // full program: walk writes, walk reads, inhibit check, per-pin checks
  function automatic seq_op_t step_op(int unsigned s);
    seq_op_t     op;
    int unsigned k;
    op      = '0;
    op.mask = {SEQ_DW{1'b1}};
    if (s < N_WALK) begin
      op.addr = therm_addr(s);
      op.data = gray_code(s);
    end else if (s < 2 * N_WALK) begin
      k          = s - N_WALK;
      op.is_read = 1'b1;
      op.addr    = therm_addr(k);
      op.data    = gray_code(k);
    end else if (s < 2 * N_WALK + N_INH) begin
      k          = s - 2 * N_WALK;
      op.inhibit = (k == 1);
      op.is_read = (k == 2);
      op.data    = (k == 1) ? {SEQ_DW{1'b0}} : {SEQ_DW{1'b1}};
    end else begin
      k          = s - 2 * N_WALK - N_INH;
      op.mask    = data_t'(1) << (k >> 2);
      op.is_read = k[0];
      op.data    = k[1] ? op.mask : {SEQ_DW{1'b0}};
    end
    return op;
  endfunction

endpackage

// File: rtl/sram_seq_prog.sv
module sram_seq_prog
  import sram_seq_pkg::*;
(
  input  step_t   step,
  output seq_op_t op
);

  assign op = step_op(32'(step));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned ENABLE_CYC = 1,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned READ_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_read,
  input  logic       mism_evt,
  output seq_state_t state,
  output seq_phase_t phase,
  output step_t      step,
  output logic       start_acc,
  output logic       sample_evt
);

  localparam int unsigned MAX_LEN = SETUP_CYC + ENABLE_CYC + STROBE_CYC + HOLD_CYC + READ_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  function automatic int unsigned phase_len(seq_phase_t p);
    case (p)
      PH_SETUP:  return SETUP_CYC;
      PH_ENABLE: return ENABLE_CYC;
      PH_STROBE: return STROBE_CYC;
      PH_HOLD:   return HOLD_CYC;
      PH_READ:   return READ_CYC;
      default:   return 1;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             ph_last;
  logic             step_last;

  assign run        = (state == ST_RUN);
  assign ph_last    = (32'(cnt) == phase_len(phase) - 1);
  assign step_last  = (32'(step) == N_STEPS - 1);
  assign start_acc  = start && !run;
  assign sample_evt = run && (phase == PH_READ) && ph_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= PH_SETUP;
      step  <= '0;
      cnt   <= '0;
    end else if (start_acc) begin
      state <= ST_RUN;
      phase <= PH_SETUP;
      step  <= '0;
      cnt   <= '0;
    end else if (run) begin
      if (!ph_last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (phase)
          PH_SETUP:  phase <= is_read ? PH_READ : PH_ENABLE;
          PH_ENABLE: phase <= PH_STROBE;
          PH_STROBE: phase <= PH_HOLD;
          default: begin
            if (mism_evt || step_last) begin
              state <= ST_FIN;
            end else begin
              step  <= step + 1'b1;
              phase <= PH_SETUP;
            end
          end
        endcase
      end
    end
  end

  // R3: the write strobe is always followed by the completion phase
  p_strobe_then_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(phase) == PH_STROBE && phase != PH_STROBE) |-> (phase == PH_HOLD));

  // R7: a read phase is entered only from address setup
  p_read_after_setup_r7: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && phase == PH_READ && $past(phase) != PH_READ) |-> ($past(phase) == PH_SETUP));

endmodule

// File: rtl/sram_seq_check.sv
module sram_seq_check
  import sram_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_acc,
  input  logic  sample_evt,
  input  addr_t op_addr,
  input  data_t op_data,
  input  data_t op_mask,
  input  data_t dq_in,
  output logic  mism_evt,
  output logic  fail,
  output addr_t fail_addr,
  output data_t fail_exp,
  output data_t fail_act
);

  data_t diff;

  assign diff     = (dq_in ^ op_data) & op_mask;
  assign mism_evt = sample_evt && (diff != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else if (start_acc) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else if (mism_evt && !fail) begin
      fail      <= 1'b1;
      fail_addr <= op_addr;
      fail_exp  <= op_data & op_mask;
      fail_act  <= dq_in & op_mask;
    end
  end

  // R8: the failure record holds until a new start
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !start_acc) |=> (fail && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));

  // R8: a recorded failure always differs in at least one bit
  p_fail_differs_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (fail_exp != fail_act));

endmodule

// File: rtl/sram_test_seq.sv
module sram_test_seq
  import sram_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned ENABLE_CYC = 1,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned READ_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [SEQ_AW-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic [SEQ_DW-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [SEQ_DW-1:0] ram_dq_in,
  output logic              done,
  output logic              fail,
  output logic [SEQ_AW-1:0] fail_addr,
  output logic [SEQ_DW-1:0] fail_exp,
  output logic [SEQ_DW-1:0] fail_act
);

  seq_state_t state;
  seq_phase_t phase;
  step_t      step;
  seq_op_t    op;
  logic       start_acc;
  logic       sample_evt;
  logic       mism_evt;
  logic       run;
  logic       op_inhibit;

  sram_seq_prog u_prog (
    .step (step),
    .op   (op)
  );

  sram_seq_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .ENABLE_CYC (ENABLE_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .READ_CYC   (READ_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .is_read    (op.is_read),
    .mism_evt   (mism_evt),
    .state      (state),
    .phase      (phase),
    .step       (step),
    .start_acc  (start_acc),
    .sample_evt (sample_evt)
  );

  sram_seq_check u_check (
    .clk        (clk),
    .rst        (rst),
    .start_acc  (start_acc),
    .sample_evt (sample_evt),
    .op_addr    (op.addr),
    .op_data    (op.data),
    .op_mask    (op.mask),
    .dq_in      (ram_dq_in),
    .mism_evt   (mism_evt),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_exp   (fail_exp),
    .fail_act   (fail_act)
  );

  assign run        = (state == ST_RUN);
  assign op_inhibit = op.inhibit;
  assign done       = (state == ST_FIN);

  assign ram_addr   = run ? op.addr : '0;
  assign ram_ce_n   = !(run && !op_inhibit &&
                        (phase == PH_ENABLE || phase == PH_STROBE || phase == PH_READ));
  assign ram_we_n   = !(run && phase == PH_STROBE);
  assign ram_dq_oe  = run && (phase == PH_STROBE || phase == PH_HOLD);
  assign ram_dq_out = ram_dq_oe ? op.data : '0;

  // R2: driving starts only under a low write strobe
  p_drive_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> !ram_we_n);

  // R2: bus released in and before the cycle chip select falls
  p_release_before_ce_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_ce_n) |-> (!ram_dq_oe && !$past(ram_dq_oe)));

  // R2: never drive while the RAM is driving
  p_no_contention_r2: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && ram_we_n) |-> !ram_dq_oe);

  // R3: strobe falls on a stable address, chip selected unless inhibited
  p_strobe_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> ($stable(ram_addr) && (!ram_ce_n || op_inhibit)));

  // R3: write completes with both controls high and data still driven
  p_write_complete_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (ram_ce_n && ram_dq_oe));

  // R7: sampling happens only in a genuine read cycle
  p_sample_read_r7: assert property (@(posedge clk) disable iff (rst)
    sample_evt |-> (!ram_ce_n && ram_we_n && !ram_dq_oe));

  // R9: finished sequencer leaves the RAM quiet
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (ram_ce_n && ram_we_n && !ram_dq_oe));

endmodule

// File: tb/sim_sram_test_seq.sv
`timescale 1ns/1ps
module sim_sram_test_seq;

  localparam int TB_S = 2, TB_E = 1, TB_T = 3, TB_H = 1, TB_R = 2;
  localparam int WR_CYC = TB_S + TB_E + TB_T + TB_H;
  localparam int RD_CYC = TB_S + TB_R;
  localparam int LIMIT  = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_dq_oe;
  logic [3:0]  ram_dq_out, ram_dq_in;
  logic        done, fail;
  logic [11:0] fail_addr;
  logic [3:0]  fail_exp, fail_act;

  always #4 clk = ~clk;

  sram_test_seq #(
    .SETUP_CYC(TB_S), .ENABLE_CYC(TB_E), .STROBE_CYC(TB_T), .HOLD_CYC(TB_H), .READ_CYC(TB_R)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // ---------------- RAM model with fault options ----------------
  logic [3:0] mem [0:4095];
  bit         ce_bug = 0, f_on = 0;
  int         f_addr = 0, f_mask = 0, f_val = 0, f_from = 0;
  int         rd_idx = 0, wr_count = 0, wr_at_first_rd = -1;
  int         order_err = 0, strobe_err = 0, cont_err = 0, rel_err = 0, rdlen_err = 0;
  logic [3:0] rv;

  always_comb begin
    rv = mem[ram_addr];
    if (f_on && int'(ram_addr) == f_addr && rd_idx >= f_from)
      rv = (rv & ~4'(f_mask)) | (4'(f_val) & 4'(f_mask));
    ram_dq_in = (!ram_ce_n && ram_we_n) ? rv : 4'h0;
  end

  bit         prev_act = 0, ce_prev = 1, we_prev = 1, oe_prev = 0, saw_we_low = 0;
  logic [11:0] prev_a = '0;
  logic [3:0]  prev_d = '0;
  int          we_low = 0, ce_low = 0;

  always @(negedge clk) begin
    bit act;
    act = !ram_we_n && ram_dq_oe && (!ram_ce_n || ce_bug);
    if (prev_act && !act) begin
      mem[prev_a] <= prev_d;
      wr_count++;
      if (!(ram_ce_n && ram_we_n && ram_dq_oe)) order_err++;
    end
    if (act) begin prev_a = ram_addr; prev_d = ram_dq_out; end
    prev_act = act;
    if (ram_dq_oe && !ram_ce_n && ram_we_n) cont_err++;
    if (ce_prev && !ram_ce_n && (ram_dq_oe || oe_prev)) rel_err++;
    if (!ram_we_n) we_low++;
    else if (we_low != 0) begin if (we_low != TB_T) strobe_err++; we_low = 0; end
    if (!ram_ce_n) begin ce_low++; if (!ram_we_n) saw_we_low = 1; end
    else if (ce_low != 0) begin
      if (!saw_we_low) begin
        if (ce_low != TB_R) rdlen_err++;
        if (rd_idx == 0) wr_at_first_rd = wr_count;
        rd_idx++;
      end
      ce_low = 0; saw_we_low = 0;
    end
    ce_prev = ram_ce_n; we_prev = ram_we_n; oe_prev = ram_dq_oe;
  end

  // ---------------- reference program ----------------
  typedef struct { bit rd; bit inh; int a; int d; int m; } op_s;
  op_s prog[$];

  task automatic push(bit rd, bit inh, int a, int d, int m);
    op_s o; o.rd = rd; o.inh = inh; o.a = a; o.d = d; o.m = m; prog.push_back(o);
  endtask

  function automatic int walk_addr(int i); return (2 ** i) - 1; endfunction
  function automatic int walk_data(int i); return (i ^ (i / 2)) % 16; endfunction

  task automatic build_prog();
    for (int i = 0; i < 13; i++) push(0, 0, walk_addr(i), walk_data(i), 15);
    for (int i = 0; i < 13; i++) push(1, 0, walk_addr(i), walk_data(i), 15);
    push(0, 0, 0, 15, 15); push(0, 1, 0, 0, 15); push(1, 0, 0, 15, 15);
    for (int b = 0; b < 4; b++) begin
      push(0, 0, 0, 0, 1 << b);      push(1, 0, 0, 0, 1 << b);
      push(0, 0, 0, 1 << b, 1 << b); push(1, 0, 0, 1 << b, 1 << b);
    end
  endtask

  task automatic replay(output bit ef, output int ea, output int ee, output int eact,
                        output int ecyc, output int ewr);
    int rm [int];
    int ridx = 0;
    int v;
    ef = 0; ea = 0; ee = 0; eact = 0; ecyc = 0; ewr = 0;
    foreach (prog[i]) begin
      if (!prog[i].rd) begin
        ecyc += WR_CYC;
        if (!prog[i].inh || ce_bug) begin rm[prog[i].a] = prog[i].d; ewr++; end
      end else begin
        ecyc += RD_CYC;
        v = rm.exists(prog[i].a) ? rm[prog[i].a] : 0;
        if (f_on && prog[i].a == f_addr && ridx >= f_from) v = (v & ~f_mask & 15) | (f_val & f_mask);
        ridx++;
        if (((v ^ prog[i].d) & prog[i].m) != 0) begin
          ef = 1; ea = prog[i].a; ee = prog[i].d & prog[i].m; eact = v & prog[i].m;
          return;
        end
      end
    end
  endtask

  // ---------------- checking ----------------
  int checks = 0, errors = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_sim();
  end

  int cyc;

  task automatic run_prog(int poke);
    for (int i = 0; i < 4096; i++) mem[i] = 4'h0;
    rd_idx = 0; wr_count = 0; wr_at_first_rd = -1;
    order_err = 0; strobe_err = 0; cont_err = 0; rel_err = 0; rdlen_err = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < LIMIT) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      start = (cyc == poke);
    end
    start = 1'b0;
    if (cyc >= LIMIT) chk("R9", "run timeout", cyc, -1);
  endtask

  task automatic judge(string req);
    bit ef; int ea, ee, eact, ecyc, ewr;
    replay(ef, ea, ee, eact, ecyc, ewr);
    chk(req, "done", int'(done), 1);
    chk(req, "fail", int'(fail), int'(ef));
    chk("R9", "cycles to done", cyc, ecyc);
    if (ef) begin
      chk("R8", "fail_addr", int'(fail_addr), ea);
      chk("R8", "fail_exp", int'(fail_exp), ee);
      chk("R8", "fail_act", int'(fail_act), eact);
    end else begin
      chk(req, "writes landed", wr_count, ewr);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    build_prog();
    for (int i = 0; i < 4096; i++) mem[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1", "ce_n idle", int'(ram_ce_n), 1);
    chk("R1", "we_n idle", int'(ram_we_n), 1);
    chk("R1", "oe idle", int'(ram_dq_oe), 0);
    chk("R1", "done idle", int'(done), 0);
    chk("R1", "fail idle", int'(fail), 0);

    // clean run with a start poke in the middle (R10)
    run_prog(50);
    judge("R10");
    chk("R4", "writes before first read", wr_at_first_rd, 13);
    for (int i = 1; i < 13; i++) chk("R4", "walk word", int'(mem[walk_addr(i)]), walk_data(i));
    chk("R6", "addr0 after pin tests", int'(mem[0]), 8);
    chk("R2", "contention", cont_err, 0);
    chk("R2", "bus release before select", rel_err, 0);
    chk("R3", "write completion order", order_err, 0);
    chk("R3", "strobe width", strobe_err, 0);
    chk("R7", "read select width", rdlen_err, 0);
    chk("R9", "quiet when done", int'(ram_ce_n && ram_we_n && !ram_dq_oe), 1);

    // RAM that ignores chip select on writes: inhibit check must fail (R5)
    ce_bug = 1;
    run_prog(0);
    judge("R5");
    chk("R5", "inhibit fail addr", int'(fail_addr), 0);
    chk("R5", "inhibit fail exp", int'(fail_exp), 15);
    chk("R5", "inhibit fail act", int'(fail_act), 0);
    repeat (5) @(negedge clk);
    chk("R8", "record held", int'({fail, done, fail_addr, fail_exp, fail_act}),
        int'({1'b1, 1'b1, 12'h000, 4'hF, 4'h0}));
    ce_bug = 0;

    // fault only on the final read: mismatch on the completion edge (R6)
    f_on = 1; f_addr = 0; f_mask = 8; f_val = 0; f_from = 21;
    run_prog(0);
    judge("R6");
    chk("R6", "last read fail_exp", int'(fail_exp), 8);

    // random stuck bits
    for (int n = 0; n < 8; n++) begin
      f_on   = 1;
      f_addr = ($urandom % 4 == 0) ? int'($urandom % 4096) : walk_addr(int'($urandom % 13));
      f_mask = 1 << ($urandom % 4);
      f_val  = int'($urandom % 16);
      f_from = 0;
      run_prog(0);
      judge("R4");
    end
    f_on = 0;

    // restart after a failure clears fail (R10)
    run_prog(0);
    judge("R10");
    chk("R10", "fail cleared", int'(fail), 0);

    // reset in the middle of a run (R11)
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R11", "idle after reset", int'({ram_ce_n, ram_we_n, ram_dq_oe, done, fail}), 5'b11000);
    repeat (20) @(negedge clk);
    chk("R11", "stays idle", int'({ram_ce_n, ram_we_n, ram_dq_oe, done}), 4'b1100);

    finish_sim();
  end

endmodule